// File: doc/BRIEF.md
# Three-Input Truth-Table Logic Unit

This datapath unit applies one programmable three-input Boolean function across whole operand words. Three operand words of equal width enter together with an 8-bit function code. At every bit position the three operand bits form a 3-bit index, and the result bit is the function-code bit at that index. Each of the 256 code values therefore selects one of the 256 possible three-input bitwise functions. Bit positions are fully independent, with no carry or ripple between them.

The function code comes either from an instruction immediate or from the low byte of a register operand. When the register source is chosen, the unit behaves as a row of three-input lookup cells that all share one configuration word. A request is qualified by a valid bit. The result is returned with its own valid bit, either in the same cycle or after one register stage, as a parameter chooses. The operand width is a parameter and is 64 by default.

Top module: `tri_lut_unit`

## Requirements
- R1: For every bit position i, rsp_data[i] equals the effective code bit at index {op_c[i], op_b[i], op_a[i]}. op_c supplies index bit 2, op_b bit 1 and op_a bit 0.
- R2: When code_from_reg is 1, the effective code is code_reg[7:0], and code_imm and code_reg above bit 7 have no effect. When code_from_reg is 0, the effective code is code_imm.
- R3: Changing one operand bit at position k can change only result bit k.
- R4: Code 0x00 gives an all-zero result and code 0xFF an all-ones result, for any operands.
- R5: Code 0x80 gives op_a & op_b & op_c, and code 0xFE gives op_a | op_b | op_c.
- R6: Code 0xCA gives a blend: where op_c is 1 the result takes op_b, and elsewhere it takes op_a.
- R7: Code 0x96 gives op_a ^ op_b ^ op_c, and code 0xE8 gives the bitwise majority of the three operands.
- R8: With PIPELINED=1, rsp_valid equals req_valid from the previous clock, and rsp_data then holds the result of that request.
- R9: With PIPELINED=1, a synchronous reset (rst high at a clock edge) clears rsp_valid and rsp_data to zero, and a request presented during reset is dropped.
- R10: With PIPELINED=0, rsp_valid follows req_valid and rsp_data follows the operands in the same cycle, with no clock involved.
- R11: With PIPELINED=1, a clock edge with req_valid low leaves rsp_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional result register |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request qualifier |
| op_a | input | WIDTH | Operand giving index bit 0 |
| op_b | input | WIDTH | Operand giving index bit 1 |
| op_c | input | WIDTH | Operand giving index bit 2 |
| code_imm | input | 8 | Function code taken from an immediate |
| code_reg | input | WIDTH | Register word whose low byte can serve as the function code |
| code_from_reg | input | 1 | 1 selects code_reg[7:0], 0 selects code_imm |
| rsp_valid | output | 1 | Result qualifier |
| rsp_data | output | WIDTH | Result word |

## Verification
The bench runs a registered copy and a combinational copy side by side on the same stimulus. The combinational result is due in the same cycle, so the bench samples it a short delay after it drives the inputs at the falling edge. The registered result is due one rising edge later, so the bench holds the expectation for that request and compares it at the following falling edge, before it drives the next inputs. When valid is low or reset is asserted, the held expectation stays the same or is set to zero. The expectations come from a model that loops over bit positions, and from separate closed-form expressions for the named codes.

// File: rtl/lut3_pkg.sv
package lut3_pkg;
   localparam int IDX_BITS  = 3;
   localparam int CODE_BITS = 1 << IDX_BITS;

   typedef logic [CODE_BITS-1:0] fcode_t;

   localparam fcode_t FC_ZERO  = 8'h00;
   localparam fcode_t FC_ONES  = 8'hFF;
   localparam fcode_t FC_AND3  = 8'h80;
   localparam fcode_t FC_OR3   = 8'hFE;
   localparam fcode_t FC_BLEND = 8'hCA;
   localparam fcode_t FC_XOR3  = 8'h96;
   localparam fcode_t FC_MAJ3  = 8'hE8;
endpackage

// File: rtl/lut3_code_sel.sv
module lut3_code_sel
   import lut3_pkg::*;
#(
   parameter int W = 64
) (
   input  fcode_t         imm_code,
   input  logic [W-1:0]   reg_word,
   input  logic           from_reg,
   output fcode_t         code
);
   assign code = from_reg ? reg_word[CODE_BITS-1:0] : imm_code;

   generate
      if (W > CODE_BITS) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^reg_word[W-1:CODE_BITS];
      end
   endgenerate
endmodule

// File: rtl/lut3_slice_array.sv
module lut3_slice_array
   import lut3_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   input  fcode_t       code,
   output logic [W-1:0] y
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic [IDX_BITS-1:0] idx;
         assign idx  = {c[i], b[i], a[i]};
         assign y[i] = code[idx];
      end
   endgenerate

   // R4: the constant codes force the whole word regardless of operands
   always_comb begin
      if (code == FC_ZERO) begin
         a_r4_zero_code: assert (y == '0);
      end
      if (code == FC_ONES) begin
         a_r4_ones_code: assert (y == '1);
      end
   end
endmodule

// File: rtl/lut3_out_stage.sv
module lut3_out_stage #(
   parameter int W         = 64,
   parameter bit PIPELINED = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   generate
      if (PIPELINED) begin : g_reg
         logic         v_q;
         logic [W-1:0] d_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               v_q <= 1'b0;
               d_q <= '0;
            end else begin
               v_q <= in_valid;
               if (in_valid) d_q <= in_data;
            end
         end

         assign out_valid = v_q;
         assign out_data  = d_q;

         a_r8_valid_rise: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
         a_r8_valid_low: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
         a_r8_data_load: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (out_data == $past(in_data)));
         a_r11_data_hold: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(out_data));
         a_r9_reset_clear: assert property (@(posedge clk)
            rst |=> (!out_valid && out_data == '0));
      end else begin : g_comb
         logic unused_ctl;
         assign unused_ctl = clk ^ rst;
         assign out_valid  = in_valid;
         assign out_data   = in_data;
      end
   endgenerate
endmodule

// File: rtl/tri_lut_unit.sv
module tri_lut_unit
   import lut3_pkg::*;
#(
   parameter int WIDTH     = 64,
   parameter bit PIPELINED = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [WIDTH-1:0] op_c,
   input  logic [7:0]       code_imm,
   input  logic [WIDTH-1:0] code_reg,
   input  logic             code_from_reg,
   output logic             rsp_valid,
   output logic [WIDTH-1:0] rsp_data
);
   generate
      if (WIDTH < CODE_BITS) begin : g_bad_width
         $error("tri_lut_unit: WIDTH must hold a full function code");
      end
      if (CODE_BITS != 8) begin : g_bad_code
         $error("tri_lut_unit: function code port is 8 bits wide");
      end
   endgenerate

   fcode_t           code_w;
   logic [WIDTH-1:0] slice_y;

   lut3_code_sel #(.W(WIDTH)) u_sel (
      .imm_code (code_imm),
      .reg_word (code_reg),
      .from_reg (code_from_reg),
      .code     (code_w)
   );

   lut3_slice_array #(.W(WIDTH)) u_arr (
      .a    (op_a),
      .b    (op_b),
      .c    (op_c),
      .code (code_w),
      .y    (slice_y)
   );

   lut3_out_stage #(.W(WIDTH), .PIPELINED(PIPELINED)) u_out (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (req_valid),
      .in_data   (slice_y),
      .out_valid (rsp_valid),
      .out_data  (rsp_data)
   );

   a_r5_and3: assert property (@(posedge clk) disable iff (rst)
      (code_w == FC_AND3) |-> (slice_y == (op_a & op_b & op_c)));
   a_r5_or3: assert property (@(posedge clk) disable iff (rst)
      (code_w == FC_OR3) |-> (slice_y == (op_a | op_b | op_c)));
   a_r6_blend: assert property (@(posedge clk) disable iff (rst)
      (code_w == FC_BLEND) |-> (slice_y == ((op_c & op_b) | (~op_c & op_a))));
   a_r7_xor3: assert property (@(posedge clk) disable iff (rst)
      (code_w == FC_XOR3) |-> (slice_y == (op_a ^ op_b ^ op_c)));
endmodule

// File: tb/sim_tri_lut_unit.sv
`timescale 1ns/1ps
module sim_tri_lut_unit;
   localparam int W = 64;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         req_valid = 1'b0;
   logic [W-1:0] op_a = '0, op_b = '0, op_c = '0, code_reg = '0;
   logic [7:0]   code_imm = '0;
   logic         code_from_reg = 1'b0;
   logic         v0, v1;
   logic [W-1:0] d0, d1;

   int    n_chk = 0;
   int    n_err = 0;
   logic         exp_v = 1'b0;
   logic [W-1:0] exp_d = '0;
   string        exp_tag = "R9";

   always #2.5 clk = ~clk;

   tri_lut_unit #(.WIDTH(W), .PIPELINED(1'b1)) u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .op_a(op_a), .op_b(op_b),
      .op_c(op_c), .code_imm(code_imm), .code_reg(code_reg),
      .code_from_reg(code_from_reg), .rsp_valid(v0), .rsp_data(d0));

   tri_lut_unit #(.WIDTH(W), .PIPELINED(1'b0)) u1 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .op_a(op_a), .op_b(op_b),
      .op_c(op_c), .code_imm(code_imm), .code_reg(code_reg),
      .code_from_reg(code_from_reg), .rsp_valid(v1), .rsp_data(d1));

   function automatic logic [W-1:0] model(input logic [W-1:0] a, b, c,
                                          input logic [7:0] f);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) begin
         int k = 0;
         if (a[i]) k += 1;
         if (b[i]) k += 2;
         if (c[i]) k += 4;
         r[i] = f[k];
      end
      return r;
   endfunction

   function automatic logic [W-1:0] rnd();
      return {$urandom(), $urandom()};
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] got, exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic check_u0();
      chk({exp_tag, " valid"}, {{(W-1){1'b0}}, v0}, {{(W-1){1'b0}}, exp_v});
      chk({exp_tag, " data"}, d0, exp_d);
   endtask

   // one request cycle: check the pending registered result, drive, check the comb copy
   task automatic step(input logic v, input logic [W-1:0] a, b, c,
                       input logic [7:0] imm, input logic [W-1:0] rg,
                       input logic sel, input string tag);
      logic [7:0]   f;
      logic [W-1:0] e;
      @(negedge clk);
      check_u0();
      req_valid = v; op_a = a; op_b = b; op_c = c;
      code_imm = imm; code_reg = rg; code_from_reg = sel;
      #1;
      f = sel ? rg[7:0] : imm;
      e = model(a, b, c, f);
      chk({tag, " R10 comb valid"}, {{(W-1){1'b0}}, v1}, {{(W-1){1'b0}}, v});
      chk({tag, " comb data"}, d1, e);
      exp_v   = v;
      if (v) exp_d = e;
      exp_tag = v ? {tag, " R8 registered"} : {tag, " R11 hold"};
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [W-1:0] a, b, c, base, m;
      logic [7:0]   f;
      // R9: reset state
      repeat (2) @(negedge clk);
      chk("R9 reset valid", {{(W-1){1'b0}}, v0}, '0);
      chk("R9 reset data", d0, '0);
      rst = 1'b0;

      // R1: every code from the immediate, random operands
      for (int k = 0; k < 256; k++)
         step(1'b1, rnd(), rnd(), rnd(), 8'(k), rnd(), 1'b0, "R1 imm");

      // R2: every code from the register, garbage in imm and upper bits
      for (int k = 0; k < 256; k++)
         step(1'b1, rnd(), rnd(), rnd(), 8'(~k), {rnd() & ~64'hFF} | 64'(k),
              1'b1, "R2 reg");

      // R1: all-zero and all-one operand corners, every code
      for (int k = 0; k < 256; k++) begin
         step(1'b1, '0, '0, '0, 8'(k), '0, 1'b0, "R1 zeros");
         step(1'b1, '1, '1, '1, 8'(k), '0, 1'b0, "R1 ones");
      end

      // R4..R7: named codes against closed-form expressions
      for (int t = 0; t < 8; t++) begin
         a = rnd(); b = rnd(); c = rnd();
         step(1'b1, a, b, c, 8'h00, '0, 1'b0, "R4 zero");
         chk("R4 zero code", d1, '0);
         step(1'b1, a, b, c, 8'h5A, 64'hFF, 1'b1, "R4 ones");
         chk("R4 ones code", d1, '1);
         step(1'b1, a, b, c, 8'h80, '0, 1'b0, "R5 and");
         chk("R5 and3", d1, a & b & c);
         step(1'b1, a, b, c, 8'h00, 64'hFE, 1'b1, "R5 or");
         chk("R5 or3", d1, a | b | c);
         step(1'b1, a, b, c, 8'hCA, '0, 1'b0, "R6 blend");
         chk("R6 blend", d1, (c & b) | (~c & a));
         step(1'b1, a, b, c, 8'h96, '0, 1'b0, "R7 xor");
         chk("R7 xor3", d1, a ^ b ^ c);
         step(1'b1, a, b, c, 8'hE8, '0, 1'b0, "R7 maj");
         chk("R7 majority", d1, (a & b) | (a & c) | (b & c));
      end

      // R3: single-bit flips stay at their own position
      a = rnd(); b = rnd(); c = rnd(); f = 8'h6B;
      step(1'b1, a, b, c, f, '0, 1'b0, "R3 base");
      base = d1;
      for (int k = 0; k < W; k++) begin
         m = '0; m[k] = 1'b1;
         step(1'b1, a, b ^ m, c, f, '0, 1'b0, "R3 flip");
         chk("R3 other bits", d1 & ~m, base & ~m);
      end

      // R8 / R11: valid gaps with changing operands
      for (int t = 0; t < 20; t++)
         step(t % 3 == 0, rnd(), rnd(), rnd(), 8'($urandom()), rnd(), 1'($urandom()),
              "R8 gap");

      // R9: reset in mid-run drops a request presented during it
      step(1'b1, '1, '1, '1, 8'hFF, '0, 1'b0, "R9 pre");
      @(negedge clk);
      check_u0();
      rst = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      chk("R9 mid reset valid", {{(W-1){1'b0}}, v0}, '0);
      chk("R9 mid reset data", d0, '0);
      rst = 1'b0; req_valid = 1'b0;
      exp_v = 1'b0; exp_d = '0; exp_tag = "R9 after reset";
      step(1'b0, rnd(), rnd(), rnd(), 8'hFF, '0, 1'b0, "R9 idle");
      step(1'b0, '0, '0, '0, 8'h00, '0, 1'b0, "drain");
      @(negedge clk);
      check_u0();

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule